// File: doc/BRIEF.md
# Aliased Multi-Width Floating-Point Register File

This block holds the architectural floating-point registers of a core as one flat array of 32-bit words. A register index selects one word, and a size code chooses whether the access is a single (32-bit), double (64-bit) or quad (128-bit) value. A wider value occupies the word at the index and the words that follow it. The single, double and quad views therefore share the same bits: a double written at index 4 can be read back as the singles at 4 and 5, or as part of a quad starting at 2.

Reads are combinational from the addressed words. Writes commit on the next rising clock edge and update every covered word at once. An illegal size code, or a wide access that would run past the last word, raises an error flag. In that case nothing is written and the read data is forced to zero. A synchronous clear input zeroes the whole array in one edge.

Top module: `fpr_alias_file`

## Requirements
- R1: After reset every word reads as zero.
- R2: Size code 2'b00 selects single, 2'b01 double and 2'b10 quad. Code 2'b11 is illegal: it drives err_o high and rdata_o to zero, and a write with this code changes no word.
- R3: A single read returns the word at idx_i in rdata_o[31:0], with rdata_o[127:32] zero.
- R4: A double read returns {word[idx_i], word[idx_i+1]} in rdata_o[63:0], with the lower-indexed word in bits 63:32 and rdata_o[127:64] zero.
- R5: A quad read returns {word[idx_i], word[idx_i+1], word[idx_i+2], word[idx_i+3]} in rdata_o[127:0], with the lower-indexed word most significant.
- R6: A write uses the same bit placement as the read of the same size. It updates every covered word on one clock edge, and a read in the next cycle returns the new data. Words outside the span are unchanged.
- R7: Any index is legal for any size. Values written at one size are visible through the overlapping words at every other size.
- R8: When idx_i plus the span (1, 2 or 4 words) exceeds NUM_WORDS, err_o is high, rdata_o is zero and a write changes no word.
- R9: A high clr_i zeroes every word on the next edge. Clear takes priority over a simultaneous write.
- R10: With we_i low and clr_i low, no word changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, zeroes storage |
| clr_i | input | 1 | Synchronous clear of all words |
| idx_i | input | $clog2(NUM_WORDS) | Index of the first word of the access |
| size_i | input | 2 | Access size code |
| we_i | input | 1 | Write enable |
| wdata_i | input | 128 | Write data, right-aligned per size |
| rdata_o | output | 128 | Read data, right-aligned per size |
| err_o | output | 1 | Illegal size or span overrun |

## Verification
The bench builds the block with NUM_WORDS set to 8, which puts the end of storage within a few indices. At that size the full cross of sizes and indices can be swept. Every write at every size and start index is followed by a read-back of all 32 size/index pairs against a word-level model. This covers every overrun boundary, every aliasing overlap and the no-write behaviour of rejected accesses. Separate passes check the behaviour with write enable held low and clear colliding with a write.

// File: rtl/fpr_alias_pkg.sv
package fpr_alias_pkg;

    typedef enum logic [1:0] {
        SZ_SINGLE = 2'b00,
        SZ_DOUBLE = 2'b01,
        SZ_QUAD   = 2'b10,
        SZ_BAD    = 2'b11
    } fpr_size_e;

    localparam int LANES = 4;

    // Number of 32-bit words an access of this size covers; 0 when illegal.
    function automatic logic [2:0] span_words(fpr_size_e sz);
        logic [2:0] n;
        unique case (sz)
            SZ_SINGLE: n = 3'd1;
            SZ_DOUBLE: n = 3'd2;
            SZ_QUAD:   n = 3'd4;
            default:   n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fpr_span_check.sv
module fpr_span_check
    import fpr_alias_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [1:0]       size_i,
    output logic [2:0]       span_o,
    output logic             bad_o
);
    localparam int SUM_W = IDX_W + 3;

    logic [SUM_W-1:0] end_excl;

    always_comb begin
        span_o   = span_words(fpr_size_e'(size_i));
        end_excl = SUM_W'(idx_i) + SUM_W'(span_o);
        bad_o    = (span_o == 3'd0) || (end_excl > SUM_W'(NUM_WORDS));
    end

endmodule

// File: rtl/fpr_word_bank.sv
module fpr_word_bank
    import fpr_alias_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [2:0]                  span_i,
    input  logic [LANES*WORD_W-1:0]     wdata_i,
    output logic [NUM_WORDS*WORD_W-1:0] words_o
);
    localparam int REL_W = IDX_W + 1;

    for (genvar j = 0; j < NUM_WORDS; j++) begin : g_word
        logic [REL_W-1:0]  rel;
        logic              hit;
        logic [1:0]        lane;
        logic [WORD_W-1:0] word_q;

        always_comb begin
            rel  = REL_W'(j) - {1'b0, idx_i};
            hit  = wr_en_i && (REL_W'(j) >= {1'b0, idx_i})
                           && (rel < REL_W'(span_i));
            lane = 2'(span_i - 3'd1 - 3'(rel));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clr_i) begin
                word_q <= '0;
            end else if (hit) begin
                word_q <= wdata_i[lane*WORD_W +: WORD_W];
            end
        end

        assign words_o[j*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/fpr_read_gather.sv
module fpr_read_gather
    import fpr_alias_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 6
) (
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [2:0]                  span_i,
    input  logic                        bad_i,
    output logic [LANES*WORD_W-1:0]     rdata_o
);
    localparam int ADDR_W = IDX_W + 3;

    logic [ADDR_W-1:0] addr;

    always_comb begin
        rdata_o = '0;
        addr    = '0;
        for (int k = 0; k < LANES; k++) begin
            addr = ADDR_W'(idx_i) + ADDR_W'(k);
            if (!bad_i && (3'(k) < span_i) && (addr < ADDR_W'(NUM_WORDS))) begin
                rdata_o[(int'(span_i) - 1 - k)*WORD_W +: WORD_W] =
                    words_i[int'(addr)*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/fpr_alias_file.sv
module fpr_alias_file
    import fpr_alias_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int DATA_W   = WORD_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        size_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);
    logic [2:0]                  span;
    logic                        bad;
    logic [NUM_WORDS*WORD_W-1:0] mem_flat;

    fpr_span_check #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_span (
        .idx_i  (idx_i),
        .size_i (size_i),
        .span_o (span),
        .bad_o  (bad)
    );

    fpr_word_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .wr_en_i (we_i && !bad),
        .idx_i   (idx_i),
        .span_i  (span),
        .wdata_i (wdata_i),
        .words_o (mem_flat)
    );

    fpr_read_gather #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_gather (
        .words_i (mem_flat),
        .idx_i   (idx_i),
        .span_i  (span),
        .bad_i   (bad),
        .rdata_o (rdata_o)
    );

    assign err_o = bad;

endmodule

// File: rtl/fpr_alias_file_chk.sv
module fpr_alias_file_chk #(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr_i,
    input logic [IDX_W-1:0]            idx_i,
    input logic [1:0]                  size_i,
    input logic                        we_i,
    input logic [WORD_W*4-1:0]         wdata_i,
    input logic [WORD_W*4-1:0]         rdata_o,
    input logic                        err_o,
    input logic [NUM_WORDS*WORD_W-1:0] mem_flat
);
    logic [IDX_W-1:0]  prev_idx;
    logic [WORD_W-1:0] prev_wd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_idx <= '0;
            prev_wd  <= '0;
        end else begin
            prev_idx <= idx_i;
            prev_wd  <= wdata_i[WORD_W-1:0];
        end
    end

    // R2
    illegal_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'b11) |-> (err_o && rdata_o == '0));

    // R8
    quad_overrun_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((size_i == 2'b10) && (int'(idx_i) + 4 > NUM_WORDS)) |-> (err_o && rdata_o == '0));

    // R8
    rejected_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && err_o && !clr_i) |=> $stable(mem_flat));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mem_flat == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && !clr_i) |=> $stable(mem_flat));

    // R6
    single_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i && !err_o && size_i == 2'b00) |=>
            (mem_flat[prev_idx*WORD_W +: WORD_W] == prev_wd));

endmodule

bind fpr_alias_file fpr_alias_file_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .idx_i    (idx_i),
    .size_i   (size_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .mem_flat (mem_flat)
);

// File: tb/fpr_alias_file_bench.sv
module fpr_alias_file_bench;
    localparam int N  = 8;
    localparam int IW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_i = 1'b0;
    logic [IW-1:0] idx_i = '0;
    logic [1:0]   size_i = 2'b00;
    logic         we_i = 1'b0;
    logic [127:0] wdata_i = '0;
    logic [127:0] rdata_o;
    logic         err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] model [N];

    always #2 clk = ~clk;

    fpr_alias_file #(.NUM_WORDS(N)) u_fpr_alias_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .idx_i   (idx_i),
        .size_i  (size_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .err_o   (err_o)
    );

    function automatic int span_of(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
    endfunction

    function automatic bit exp_err(int i, int s);
        return (s == 3) || (i + span_of(s) > N);
    endfunction

    function automatic logic [127:0] exp_rd(int i, int s);
        logic [127:0] r = '0;
        if (exp_err(i, s)) return '0;
        for (int k = 0; k < span_of(s); k++) r = (r << 32) | 128'(model[i + k]);
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reads every size at every index and compares with the model.
    task automatic sweep_reads(string tag);
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < N; i++) begin
                @(negedge clk);
                idx_i  = IW'(i);
                size_i = 2'(s);
                #1;
                chk({tag, (s == 0) ? " R3 single" : (s == 1) ? " R4 double" :
                          (s == 2) ? " R5 quad" : " R2 illegal"},
                    rdata_o, exp_rd(i, s));
                chk({tag, " R8 err flag"}, 128'(err_o), 128'(exp_err(i, s)));
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<100000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sweep_reads("R1 reset");

        // R6 R7 R8 R2: write at every size and index, read all views back
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < N; i++) begin
                int n = s * N + i + 1;
                logic [127:0] wd;
                for (int k = 0; k < 4; k++)
                    wd[k*32 +: 32] = 32'h5A5A_0000 ^ 32'(n * 16 + k);
                @(negedge clk);
                idx_i   = IW'(i);
                size_i  = 2'(s);
                wdata_i = wd;
                we_i    = 1'b1;
                #1;
                chk("R8 write err flag", 128'(err_o), 128'(exp_err(i, s)));
                @(negedge clk);
                we_i = 1'b0;
                if (!exp_err(i, s)) begin
                    for (int k = 0; k < span_of(s); k++)
                        model[i + k] = wd[(span_of(s) - 1 - k)*32 +: 32];
                end
                sweep_reads("R6 R7 after write");
            end
        end

        // R10: we low with active-looking data does nothing
        @(negedge clk);
        idx_i = '0; size_i = 2'b10; wdata_i = {4{32'hDEAD_BEEF}}; we_i = 1'b0;
        repeat (2) @(negedge clk);
        sweep_reads("R10 idle");

        // R9: clear collides with a write; clear wins
        @(negedge clk);
        idx_i = 3'd2; size_i = 2'b01; wdata_i = {4{32'h1234_5678}};
        we_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0; clr_i = 1'b0;
        for (int k = 0; k < N; k++) model[k] = '0;
        sweep_reads("R9 clear");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule